// File: doc/BRIEF.md
# Multiplexed Bus Memory Target with Delayed Parity

This block is the target side of a synchronous parallel bus on which address and data share one set of lines and all handshakes are active low. Every input except the asynchronous reset is sampled on the rising clock edge. A transaction opens with an address cycle, marked by the start strobe `txn_n` going low. In that cycle the shared lines carry the address and the command/byte-enable lines carry the command. One or more data cycles follow, and on those cycles the same command/byte-enable lines carry active-low byte enables. The target claims a transaction only when the address falls in its word-aligned window and the command is a memory read or a memory write. A claimed transaction reads or writes a small local register file, one word per completed data phase.

A claimed transaction walks through named states. IDLE moves to CLAIM on an address cycle that hits the window (transition *accept*), or to SKIP when it misses (transition *ignore*). CLAIM always moves to DATA one cycle later (transition *ready*). DATA moves back to IDLE when a phase completes while the start strobe is high (transition *finish*). It moves to DISC when a phase completes on the top word while the start strobe is still low (transition *disconnect*). DISC moves to IDLE once the start strobe is sampled high (transition *release*). SKIP moves to IDLE once both the start strobe and the initiator ready are sampled high (transition *bus_free*).

Parity is even: it is the XOR of the shared lines and the command/byte-enable lines, and it always arrives one clock after the bits it covers. The initiator supplies it for the address cycle and for write data. The target supplies it for read data. Address-parity faults and write-data-parity faults are reported on two separate active-low flags.

Top module: `mbt_target`

## Requirements
- R1: While reset is low and after its release, `claim_n`, `tgt_rdy_n`, `abort_n`, `apar_err_n` and `dpar_err_n` are high, and `ad_oe` and `par_oe` are low.
- R2: `claim_n` goes low in the cycle after the address cycle only if address bits [31:5] equal those of `BASE` and the command is 4'b0110 (memory read) or 4'b0111 (memory write). Any other address or command leaves `claim_n` high for the whole transaction.
- R3: After a claim, `tgt_rdy_n` stays high for one decode cycle and is then held low. A data phase completes only on an edge where `tgt_rdy_n` and `ini_rdy_n` are both low. Cycles with `ini_rdy_n` high transfer nothing.
- R4: A completed write phase updates byte lane b (bits 8b+7..8b) of the addressed word only when bit b of `cbe_n` is 0. A phase with `cbe_n` = 4'b1111 leaves the word unchanged.
- R5: During read data phases `ad_oe` is high and `ad_out` carries the addressed word. The word index starts at address bits [4:2] and rises by one on each completed phase. `ad_oe` stays low during write phases.
- R6: When a phase completes with `txn_n` high, the cycle after it shows `claim_n` and `tgt_rdy_n` high and `ad_oe` low.
- R7: When a phase completes on word 7 with `txn_n` still low, the target raises `tgt_rdy_n` and drives `abort_n` low while keeping `claim_n` low. It releases all three in the cycle after `txn_n` is sampled high.
- R8: `par_oe` is high exactly in the cycle after a cycle with `ad_oe` high. In that cycle `par_out` is the XOR of the previous cycle's `ad_out` and `cbe_n`.
- R9: If `par_in` in the cycle after an address cycle differs from the XOR of that address and command, `apar_err_n` is low for exactly one cycle, the second cycle after the address cycle.
- R10: If `par_in` in the cycle after a completed write phase differs from the XOR of that phase's data and byte enables, `dpar_err_n` is low for one cycle, the second cycle after the completing cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Shared address/data lines as seen by the target |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Enable for `ad_out` |
| cbe_n | input | 4 | Command in the address cycle, active-low byte enables in data cycles |
| txn_n | input | 1 | Transaction start/continue strobe from the initiator |
| ini_rdy_n | input | 1 | Initiator ready |
| par_in | input | 1 | Parity from the initiator, one clock late |
| tgt_rdy_n | output | 1 | Target ready |
| claim_n | output | 1 | Target has claimed the transaction |
| abort_n | output | 1 | Target asks the initiator to end the transaction |
| par_out | output | 1 | Parity over read data and byte enables, one clock late |
| par_oe | output | 1 | Enable for `par_out` |
| apar_err_n | output | 1 | Address/command parity fault flag |
| dpar_err_n | output | 1 | Write-data parity fault flag |

## Verification
A wrong state in the handshake machine shows within one cycle as a ready, claim or abort strobe at the wrong time. It also appears as a missing release in the cycle after the final phase. A wrong word index or byte mask stays hidden until that word is read back, so every write pattern is followed by a read sweep that compares every lane. Parity timing faults show on the second cycle after the covered bits, where the flags or `par_out` must match a value the bench computes itself.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_CLAIM,
        ST_DATA,
        ST_DISC
    } mbt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode #(
    parameter int          DW    = 32,
    parameter int          DEPTH = 8,
    parameter logic [31:0] BASE  = 32'h4000_0000,
    localparam int         AW    = $clog2(DEPTH),
    localparam int         NB    = DW / 8
) (
    input  logic [DW-1:0] addr,
    input  logic [NB-1:0] cmd,
    output logic          hit,
    output logic          is_wr,
    output logic [AW-1:0] start_idx
);
    import mbt_pkg::*;

    logic in_window;
    logic cmd_rd;
    logic cmd_wr;

    always_comb begin
        in_window = (addr[DW-1:AW+2] == BASE[DW-1:AW+2]);
        cmd_rd    = (cmd == NB'(CMD_MEM_RD));
        cmd_wr    = (cmd == NB'(CMD_MEM_WR));
        hit       = in_window && (cmd_rd || cmd_wr);
        is_wr     = cmd_wr;
        start_idx = addr[AW+1:2];
    end

endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
    parameter int  DW    = 32,
    parameter int  DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int NB    = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [NB-1:0] wr_mask,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DW-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == AW'(w))) begin
                for (int b = 0; b < NB; b++) begin
                    if (wr_mask[b]) begin
                        word_q[b*8 +: 8] <= wr_data[b*8 +: 8];
                    end
                end
            end
        end

        assign words[w] = word_q;
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/mbt_parity.sv
module mbt_parity #(
    parameter int  DW = 32,
    localparam int NB = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_in,
    input  logic [NB-1:0] cbe_n,
    input  logic          par_in,
    input  logic          addr_stb,
    input  logic          data_stb,
    input  logic [DW-1:0] drv_data,
    input  logic          drv_oe,
    output logic          par_out,
    output logic          par_oe,
    output logic          apar_err_n,
    output logic          dpar_err_n
);
    logic bus_par;
    logic a_pend_q, a_calc_q;
    logic d_pend_q, d_calc_q;

    assign bus_par = ^{bus_in, cbe_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_pend_q   <= 1'b0;
            a_calc_q   <= 1'b0;
            d_pend_q   <= 1'b0;
            d_calc_q   <= 1'b0;
            apar_err_n <= 1'b1;
            dpar_err_n <= 1'b1;
            par_out    <= 1'b0;
            par_oe     <= 1'b0;
        end else begin
            a_pend_q <= addr_stb;
            d_pend_q <= data_stb;
            if (addr_stb) begin
                a_calc_q <= bus_par;
            end
            if (data_stb) begin
                d_calc_q <= bus_par;
            end
            apar_err_n <= !(a_pend_q && (par_in != a_calc_q));
            dpar_err_n <= !(d_pend_q && (par_in != d_calc_q));
            par_out    <= ^{drv_data, cbe_n};
            par_oe     <= drv_oe;
        end
    end

endmodule

// File: rtl/mbt_target.sv
module mbt_target #(
    parameter int          DW    = 32,
    parameter int          DEPTH = 8,
    parameter logic [31:0] BASE  = 32'h4000_0000,
    localparam int         AW    = $clog2(DEPTH),
    localparam int         NB    = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [NB-1:0] cbe_n,
    input  logic          txn_n,
    input  logic          ini_rdy_n,
    input  logic          par_in,
    output logic          tgt_rdy_n,
    output logic          claim_n,
    output logic          abort_n,
    output logic          par_out,
    output logic          par_oe,
    output logic          apar_err_n,
    output logic          dpar_err_n
);
    import mbt_pkg::*;

    mbt_state_e    st_q, st_d;
    logic          txn_q;
    logic          dec_hit, dec_wr;
    logic [AW-1:0] dec_idx;
    logic          is_wr_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] rd_idx;
    logic [DW-1:0] rd_data;
    logic          start, xfer, last_word;

    assign start     = (st_q == ST_IDLE) && !txn_n && txn_q;
    assign xfer      = (st_q == ST_DATA) && !ini_rdy_n;
    assign last_word = (ptr_q == AW'(DEPTH - 1));
    assign rd_idx    = (st_q == ST_DATA) ? ptr_q + AW'(1) : ptr_q;

    mbt_decode #(.DW(DW), .DEPTH(DEPTH), .BASE(BASE)) u_decode (
        .addr      (ad_in),
        .cmd       (cbe_n),
        .hit       (dec_hit),
        .is_wr     (dec_wr),
        .start_idx (dec_idx)
    );

    mbt_regfile #(.DW(DW), .DEPTH(DEPTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (xfer && is_wr_q),
        .wr_idx  (ptr_q),
        .wr_data (ad_in),
        .wr_mask (~cbe_n),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    mbt_parity #(.DW(DW)) u_parity (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (ad_in),
        .cbe_n      (cbe_n),
        .par_in     (par_in),
        .addr_stb   (start),
        .data_stb   (xfer && is_wr_q),
        .drv_data   (ad_out),
        .drv_oe     (ad_oe),
        .par_out    (par_out),
        .par_oe     (par_oe),
        .apar_err_n (apar_err_n),
        .dpar_err_n (dpar_err_n)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d = dec_hit ? ST_CLAIM : ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (txn_n && ini_rdy_n) begin
                    st_d = ST_IDLE;
                end
            end
            ST_CLAIM: begin
                st_d = ST_DATA;
            end
            ST_DATA: begin
                if (xfer) begin
                    if (txn_n) begin
                        st_d = ST_IDLE;
                    end else if (last_word) begin
                        st_d = ST_DISC;
                    end
                end
            end
            ST_DISC: begin
                if (txn_n) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Registered bus strobes, derived from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            claim_n   <= 1'b1;
            tgt_rdy_n <= 1'b1;
            abort_n   <= 1'b1;
            ad_oe     <= 1'b0;
        end else begin
            claim_n   <= !((st_d == ST_CLAIM) || (st_d == ST_DATA) || (st_d == ST_DISC));
            tgt_rdy_n <= !(st_d == ST_DATA);
            abort_n   <= !(st_d == ST_DISC);
            ad_oe     <= (st_d == ST_DATA) && !is_wr_q;
        end
    end

    // Transaction context and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txn_q   <= 1'b1;
            is_wr_q <= 1'b0;
            ptr_q   <= '0;
            ad_out  <= '0;
        end else begin
            txn_q <= txn_n;
            if (start) begin
                is_wr_q <= dec_wr;
                ptr_q   <= dec_idx;
            end else if (xfer && !last_word) begin
                ptr_q <= ptr_q + AW'(1);
            end
            if ((st_q == ST_CLAIM) || xfer) begin
                ad_out <= rd_data;
            end
        end
    end

endmodule

// File: rtl/mbt_target_chk.sv
module mbt_target_chk (
    input logic clk,
    input logic rst_n,
    input logic ad_oe,
    input logic tgt_rdy_n,
    input logic claim_n,
    input logic abort_n,
    input logic par_oe,
    input logic apar_err_n
);
    // R3
    rdy_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rdy_n |-> !claim_n);

    // R7
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |-> (tgt_rdy_n && !claim_n));

    // R5
    drive_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !tgt_rdy_n);

    // R8
    par_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> par_oe);

    // R8
    par_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |=> !par_oe);

    // R9
    apar_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apar_err_n |=> apar_err_n);
endmodule

bind mbt_target mbt_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad_oe      (ad_oe),
    .tgt_rdy_n  (tgt_rdy_n),
    .claim_n    (claim_n),
    .abort_n    (abort_n),
    .par_oe     (par_oe),
    .apar_err_n (apar_err_n)
);

// File: tb/mbt_target_bench.sv
module mbt_target_bench;
    localparam int          DW    = 32;
    localparam int          DEPTH = 8;
    localparam int          AW    = 3;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam logic [3:0]  RD    = 4'b0110;
    localparam logic [3:0]  WR    = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        txn_n = 1'b1;
    logic        ini_rdy_n = 1'b1;
    logic        par_in = 1'b0;
    logic [31:0] ad_out;
    logic        ad_oe, tgt_rdy_n, claim_n, abort_n, par_out, par_oe, apar_err_n, dpar_err_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_mem [DEPTH];
    logic [31:0] wdata [16];
    logic [3:0]  wbe [16];

    always #10 clk = ~clk;

    mbt_target #(.DW(DW), .DEPTH(DEPTH), .BASE(BASE)) u_mbt_target (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .cbe_n(cbe_n), .txn_n(txn_n), .ini_rdy_n(ini_rdy_n), .par_in(par_in),
        .tgt_rdy_n(tgt_rdy_n), .claim_n(claim_n), .abort_n(abort_n),
        .par_out(par_out), .par_oe(par_oe), .apar_err_n(apar_err_n), .dpar_err_n(dpar_err_n)
    );

    task automatic chkv(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic par32(input logic [31:0] d, input logic [3:0] c);
        return ^{d, c};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be_n);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) begin
            if (!be_n[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        end
        return r;
    endfunction

    task automatic drive_idle();
        ad_in = '0; cbe_n = 4'hF; txn_n = 1'b1; ini_rdy_n = 1'b1;
    endtask

    task automatic burst(input bit wr, input logic [31:0] addr, input logic [3:0] cmd, input int n,
                         input bit bad_ap, input int bad_dp, input bit waits);
        bit hit, fin, rd_v, comp, cerr, stop_exp;
        int idx, done, cyc, fin_cyc, exp_done;
        logic [1:0] dsh;
        logic [31:0] rd_q;
        logic [3:0] rd_be;
        logic nxt_par;
        hit = (addr[31:AW+2] == BASE[31:AW+2]) && (cmd == RD || cmd == WR);
        idx = int'(addr[AW+1:2]);
        exp_done = (n < DEPTH - idx) ? n : DEPTH - idx;
        fin = 0; done = 0; rd_v = 0; dsh = '0; stop_exp = 0; fin_cyc = 0;
        rd_q = '0; rd_be = '0;
        @(negedge clk);
        ad_in = addr; cbe_n = cmd; txn_n = 1'b0; ini_rdy_n = 1'b1;
        nxt_par = par32(addr, cmd) ^ bad_ap;
        cyc = 0;
        while (!(fin && cyc > fin_cyc + 2)) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                chkv(claim_n, !hit, "R2 claim after address cycle");
                chkv(tgt_rdy_n, 1, "R3 decode wait cycle");
            end else if (!hit) begin
                chkv(claim_n, 1, "R2 no claim on miss");
            end
            if (hit && cyc >= 2 && !fin && abort_n && !stop_exp)
                chkv(tgt_rdy_n, 0, "R3 ready held in data phase");
            if (cyc == 2) chkv(apar_err_n, !bad_ap, "R9 address parity flag");
            if (cyc >= 2) chkv(dpar_err_n, !dsh[1], "R10 data parity flag");
            if (rd_v) begin
                chkv(par_oe, 1, "R8 parity enable after read");
                chkv(par_out, par32(rd_q, rd_be), "R8 read parity value");
            end
            if (stop_exp) begin
                chkv(abort_n, 0, "R7 disconnect at top word");
                chkv(tgt_rdy_n, 1, "R7 ready dropped on disconnect");
                chkv(claim_n, 0, "R7 claim kept on disconnect");
            end
            if (hit && fin && cyc == fin_cyc + 1) begin
                chkv(claim_n, 1, "R6 claim released");
                chkv(tgt_rdy_n, 1, "R6 ready released");
                chkv(ad_oe, 0, "R6 drive released");
                chkv(abort_n, 1, "R7 abort released");
                chkv(done, exp_done, "R7 completed phase count");
            end
            par_in = nxt_par;
            if (fin) begin
                drive_idle();
            end else if (!hit) begin
                if (cyc == 1) begin
                    ad_in = $urandom; cbe_n = 4'h0; ini_rdy_n = 1'b0; txn_n = 1'b1;
                    fin = 1; fin_cyc = cyc + 1;
                end
            end else if (!abort_n) begin
                drive_idle();
                fin = 1; fin_cyc = cyc;
            end else begin
                ad_in = wr ? wdata[done] : 32'h0;
                cbe_n = wbe[done];
                ini_rdy_n = (waits && ($urandom % 3 == 0)) ? 1'b1 : 1'b0;
                txn_n = (done == n - 1) ? 1'b1 : 1'b0;
            end
            comp = !tgt_rdy_n && !ini_rdy_n;
            cerr = comp && wr && (done == bad_dp);
            nxt_par = par32(ad_in, cbe_n) ^ cerr;
            dsh = {dsh[0], cerr};
            rd_v = comp && !wr;
            rd_q = ad_out;
            rd_be = cbe_n;
            stop_exp = 0;
            if (comp) begin
                if (wr) begin
                    chkv(ad_oe, 0, "R5 no drive during write");
                    exp_mem[idx] = merge(exp_mem[idx], ad_in, cbe_n);
                end else begin
                    chkv(ad_oe, 1, "R5 drive during read");
                    chkv(ad_out, exp_mem[idx], "R5 R4 read data");
                end
                if (txn_n) begin
                    fin = 1; fin_cyc = cyc;
                end else if (idx == DEPTH - 1) begin
                    stop_exp = 1;
                end
                done++;
                idx++;
            end
        end
    endtask

    task automatic fill(input bit full);
        for (int i = 0; i < 16; i++) begin
            wdata[i] = $urandom;
            wbe[i] = full ? 4'h0 : 4'($urandom);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
        drive_idle();
        repeat (3) @(negedge clk);
        // R1: reset state
        chkv(claim_n, 1, "R1 claim idle"); chkv(tgt_rdy_n, 1, "R1 ready idle");
        chkv(abort_n, 1, "R1 abort idle"); chkv(ad_oe, 0, "R1 drive idle");
        chkv(par_oe, 0, "R1 parity drive idle"); chkv(apar_err_n, 1, "R1 addr flag idle");
        chkv(dpar_err_n, 1, "R1 data flag idle");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chkv(claim_n, 1, "R1 claim after reset"); chkv(tgt_rdy_n, 1, "R1 ready after reset");

        // Single full-word write and read back
        fill(1); wdata[0] = 32'hA5A5_0001;
        burst(1, BASE, WR, 1, 0, -1, 0);
        fill(1); burst(0, BASE, RD, 1, 0, -1, 0);
        // R4: masked burst, including an all-disabled phase
        fill(0); wbe[0] = 4'b0000; wbe[1] = 4'b1110; wbe[2] = 4'b0101; wbe[3] = 4'b1111;
        burst(1, BASE + 32'h8, WR, 4, 0, -1, 1);
        fill(1); burst(0, BASE + 32'h4, RD, 6, 0, -1, 1);
        // R2: window miss and non-memory command
        fill(1); burst(1, BASE + 32'h100, WR, 2, 0, -1, 0);
        fill(1); burst(1, BASE + 32'h4, 4'b0011, 1, 0, -1, 0);
        fill(1); burst(0, BASE, RD, DEPTH, 0, -1, 0);
        // R7: disconnect on writes and reads
        fill(1); burst(1, BASE + 32'h18, WR, 4, 0, -1, 0);
        fill(1); burst(0, BASE + 32'h14, RD, 5, 0, -1, 1);
        // R9, R10: injected parity faults
        fill(1); burst(1, BASE + 32'h4, WR, 1, 1, -1, 0);
        fill(1); burst(1, BASE, WR, 3, 0, 1, 0);
        fill(1); burst(1, BASE + 32'h200, RD, 1, 1, -1, 0);

        for (int t = 0; t < 40; t++) begin
            bit wr;
            logic [31:0] addr;
            logic [3:0] cmd;
            wr = 1'($urandom);
            cmd = wr ? WR : RD;
            if ($urandom % 8 == 0) cmd = 4'($urandom);
            addr = BASE + {27'h0, 3'($urandom), 2'b00};
            if ($urandom % 8 == 0) addr = addr ^ 32'h0000_0400;
            fill($urandom % 2 == 0);
            burst(wr, addr, cmd, 1 + int'($urandom % 6), ($urandom % 8 == 0),
                  ($urandom % 6 == 0) ? int'($urandom % 3) : -1, 1'($urandom));
        end
        fill(1); burst(0, BASE, RD, DEPTH, 0, -1, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule